// File: doc/BRIEF.md
# Disk DMA Transfer Progress Tracker

This block follows a storage command while a descriptor-driven DMA engine moves its data in chunks of arbitrary byte length. After a start request it captures the starting media address, the amount of work left and the command kind, then alternates between two steps. In the first it decides whether the command has finished and whether the engine has another chunk, and if so it issues that chunk with its media address. In the second it waits for the chunk to finish. Between the two it converts the finished chunk's byte length into address advance.

Two media models are supported. In sector mode the remaining work is counted in 512-byte sectors, and a partial sector is rounded up. In packet mode the remaining work is a signed byte count. A sub-block byte offset carries between chunks, the address counts 2048-byte blocks, and each chunk's media address is given in 512-byte units. Either mode finishes with a completion status and an interrupt. A chunk error or a refused launch aborts with a mode-specific error code. The engine is told to end its transfer whenever it has no more chunks or the command aborts.

Top module: `disk_xfer_tracker`

## Requirements
- R1: After reset `busy`, `chunkReq`, `irq` and `dmaEnd` are 0 and `status` is 0 (none).
- R2: A start request while idle loads the address, the work count and the command, and clears `status` to 0. The first pass adjusts no counter: the first chunk address is `startAddr` in sector mode, and `startAddr*4` in packet mode.
- R3: In sector mode a finished chunk of N bytes advances the sector address by (N+511)/512, integer division, and lowers the remaining sector count by the same amount. `chunkAddr` is the sector address.
- R4: In sector mode, every evaluation pass that finds the remaining sector count equal to 0 raises `irq` for one cycle and sets `status` to 1 (ready and seek complete).
- R5: In packet mode a finished chunk of N bytes lowers the remaining byte count by N and is added to an 11-bit offset. The block address grows by the sum divided by 2048, and the offset keeps the sum modulo 2048. `chunkAddr` = block*4 + offset/512.
- R6: In packet mode, every evaluation pass that finds the remaining byte count at or below zero raises `irq` and sets `status` to 2 (command OK).
- R7: When an evaluation pass sees `dmaLen` = 0, the block pulses `dmaEnd`, does not raise `chunkReq`, and is idle (`busy` = 0) from the next cycle.
- R8: When an evaluation pass sees a nonzero `dmaLen`, the block pulses `chunkReq` for one cycle. That pulse also tells the engine to clear its length. The block keeps `dmaLen` as the size of the chunk in flight, and only one chunk is in flight at a time.
- R9: A `chunkDone` pulse with `chunkErr` = 1 leaves every counter unchanged. In that cycle it pulses `irq` and `dmaEnd`, and it sets `status` to 3 (DMA error) in sector mode or 4 (I/O error) in packet mode. The block is then idle.
- R10: `launchFail` = 1 in a cycle where `chunkReq` is high aborts the command exactly as R9 does. The error code takes precedence over a completion found in the same pass.
- R11: `chunkCmd` carries the stored command (0 read, 1 write, 2 trim) in sector mode, and it is 0 (read) in packet mode.
- R12: A start request while `busy` = 1 is ignored: the addresses of the chunks that follow are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | Start pulse for a new command |
| startOptical | input | 1 | Mode for the new command: 1 packet, 0 sector |
| startCmd | input | 2 | Command kind: 0 read, 1 write, 2 trim |
| startAddr | input | ADDRW | Starting sector or block address |
| startLen | input | LENW | Sectors (sector mode) or bytes (packet mode) to move |
| dmaLen | input | LENW | Byte length of the next chunk offered by the DMA engine, 0 when none |
| launchFail | input | 1 | The chunk offered with `chunkReq` could not be launched |
| chunkDone | input | 1 | The chunk in flight has finished |
| chunkErr | input | 1 | Qualifies `chunkDone`: the chunk failed |
| busy | output | 1 | A command is in progress |
| chunkReq | output | 1 | Launch the chunk; the engine clears its length |
| chunkAddr | output | ADDRW+2 | Media address of the chunk, in 512-byte units |
| chunkCmd | output | 2 | Command kind presented with the chunk |
| status | output | 3 | 0 none, 1 sector done, 2 packet OK, 3 DMA error, 4 I/O error |
| irq | output | 1 | Completion or error interrupt pulse |
| dmaEnd | output | 1 | Tells the DMA engine to end its transfer |

## Verification
The bench aims at the rounding of chunks that are not a whole number of sectors. A design that truncated instead of rounding would issue a sector address one short and never reach a zero count. In packet mode it uses chunks whose offsets cross a 2048-byte boundary. A tracker that lost the carry, or that cleared the offset as sector mode does, would issue a wrong 512-byte address. Zero-length commands, which finish on the first pass, would expose a tracker that adjusted counters before any data moved. Errors, refused launches and start requests arriving mid-command would expose a design that updated counters on failure, reported the wrong error code, or restarted in the middle of a transfer.

// File: rtl/dxt_pkg.sv
package dxt_pkg;
  typedef enum logic [2:0] {
    ST_NONE      = 3'd0,
    ST_DISK_DONE = 3'd1,
    ST_PKT_DONE  = 3'd2,
    ST_DMA_ERR   = 3'd3,
    ST_IO_ERR    = 3'd4
  } stat_e;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TRIM  = 2'd2
  } cmd_e;

  typedef struct packed {
    logic  load;
    logic  take;
    logic  adv;
    logic  setStat;
    stat_e statCode;
  } strobe_t;

  localparam int SECT_SHIFT  = 9;
  localparam int BLOCK_SHIFT = 11;
endpackage

// File: rtl/dxt_datapath.sv
module dxt_datapath
  import dxt_pkg::*;
#(
  parameter int ADDRW = 32,
  parameter int LENW  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             startOptical,
  input  logic [1:0]       startCmd,
  input  logic [ADDRW-1:0] startAddr,
  input  logic [LENW-1:0]  startLen,
  input  logic [LENW-1:0]  dmaLen,
  output logic             modeOpt,
  output logic             diskDone,
  output logic             pktDone,
  output logic [ADDRW+1:0] chunkAddr,
  output logic [1:0]       chunkCmd,
  output logic [2:0]       status
);
  localparam int REMW   = LENW + 2;
  localparam int SUMW   = LENW + 1;
  localparam int OFFW   = BLOCK_SHIFT;
  localparam int ROUNDV = (1 << SECT_SHIFT) - 1;

  logic [ADDRW-1:0]       addrR;
  logic signed [REMW-1:0] remR;
  logic [OFFW-1:0]        offR;
  logic [LENW-1:0]        chunkR;
  logic [1:0]             cmdR;
  logic                   modeR;
  stat_e                  statR;

  logic [SUMW-1:0] diskStep;
  logic [SUMW-1:0] offSum;

  always_comb begin
    diskStep = ({1'b0, chunkR} + SUMW'(ROUNDV)) >> SECT_SHIFT;
    offSum   = SUMW'(offR) + {1'b0, chunkR};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR  <= '0;
      remR   <= '0;
      offR   <= '0;
      chunkR <= '0;
      cmdR   <= CMD_READ;
      modeR  <= 1'b0;
      statR  <= ST_NONE;
    end else if (strb.load) begin
      addrR  <= startAddr;
      remR   <= REMW'(startLen);
      offR   <= '0;
      chunkR <= '0;
      cmdR   <= startCmd;
      modeR  <= startOptical;
      statR  <= ST_NONE;
    end else begin
      if (strb.adv) begin
        if (modeR) begin
          remR  <= remR - REMW'(chunkR);
          addrR <= addrR + ADDRW'(offSum >> BLOCK_SHIFT);
          offR  <= offSum[OFFW-1:0];
        end else begin
          remR  <= remR - REMW'(diskStep);
          addrR <= addrR + ADDRW'(diskStep);
        end
      end
      if (strb.take) begin
        chunkR <= dmaLen;
        if (!modeR) offR <= '0;
      end
      if (strb.setStat) statR <= strb.statCode;
    end
  end

  always_comb begin
    modeOpt   = modeR;
    diskDone  = (remR == '0);
    pktDone   = (remR <= 0);
    chunkAddr = modeR ? ({addrR, 2'b00} + (ADDRW+2)'(offR >> SECT_SHIFT))
                      : {2'b00, addrR};
    chunkCmd  = modeR ? CMD_READ : cmdR;
    status    = statR;
  end
endmodule

// File: rtl/dxt_ctrl.sv
module dxt_ctrl
  import dxt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    chunkDone,
  input  logic    chunkErr,
  input  logic    launchFail,
  input  logic    lenZero,
  input  logic    modeOpt,
  input  logic    diskDone,
  input  logic    pktDone,
  output strobe_t strb,
  output logic    busy,
  output logic    chunkReq,
  output logic    irq,
  output logic    dmaEnd
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT} state_e;
  state_e st, nxt;

  stat_e errCode;
  stat_e okCode;
  logic  finished;

  always_comb begin
    errCode  = modeOpt ? ST_IO_ERR : ST_DMA_ERR;
    okCode   = modeOpt ? ST_PKT_DONE : ST_DISK_DONE;
    finished = modeOpt ? pktDone : diskDone;
  end

  always_comb begin
    strb     = '0;
    chunkReq = 1'b0;
    irq      = 1'b0;
    dmaEnd   = 1'b0;
    nxt      = st;
    case (st)
      S_IDLE: begin
        if (startReq) begin
          strb.load = 1'b1;
          nxt       = S_EVAL;
        end
      end
      S_EVAL: begin
        if (finished) begin
          strb.setStat  = 1'b1;
          strb.statCode = okCode;
          irq           = 1'b1;
        end
        if (lenZero) begin
          dmaEnd = 1'b1;
          nxt    = S_IDLE;
        end else begin
          chunkReq  = 1'b1;
          strb.take = 1'b1;
          nxt       = S_WAIT;
          if (launchFail) begin
            strb.setStat  = 1'b1;
            strb.statCode = errCode;
            irq           = 1'b1;
            dmaEnd        = 1'b1;
            nxt           = S_IDLE;
          end
        end
      end
      S_WAIT: begin
        if (chunkDone) begin
          if (chunkErr) begin
            strb.setStat  = 1'b1;
            strb.statCode = errCode;
            irq           = 1'b1;
            dmaEnd        = 1'b1;
            nxt           = S_IDLE;
          end else begin
            strb.adv = 1'b1;
            nxt      = S_EVAL;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/disk_xfer_tracker.sv
module disk_xfer_tracker
  import dxt_pkg::*;
#(
  parameter int ADDRW = 32,
  parameter int LENW  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startOptical,
  input  logic [1:0]       startCmd,
  input  logic [ADDRW-1:0] startAddr,
  input  logic [LENW-1:0]  startLen,
  input  logic [LENW-1:0]  dmaLen,
  input  logic             launchFail,
  input  logic             chunkDone,
  input  logic             chunkErr,
  output logic             busy,
  output logic             chunkReq,
  output logic [ADDRW+1:0] chunkAddr,
  output logic [1:0]       chunkCmd,
  output logic [2:0]       status,
  output logic             irq,
  output logic             dmaEnd
);
  strobe_t strb;
  logic    modeOpt;
  logic    diskDone;
  logic    pktDone;
  logic    lenZero;

  assign lenZero = (dmaLen == '0);

  dxt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .chunkDone (chunkDone),
    .chunkErr  (chunkErr),
    .launchFail(launchFail),
    .lenZero   (lenZero),
    .modeOpt   (modeOpt),
    .diskDone  (diskDone),
    .pktDone   (pktDone),
    .strb      (strb),
    .busy      (busy),
    .chunkReq  (chunkReq),
    .irq       (irq),
    .dmaEnd    (dmaEnd)
  );

  dxt_datapath #(.ADDRW(ADDRW), .LENW(LENW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .startOptical(startOptical),
    .startCmd    (startCmd),
    .startAddr   (startAddr),
    .startLen    (startLen),
    .dmaLen      (dmaLen),
    .modeOpt     (modeOpt),
    .diskDone    (diskDone),
    .pktDone     (pktDone),
    .chunkAddr   (chunkAddr),
    .chunkCmd    (chunkCmd),
    .status      (status)
  );
endmodule

// File: rtl/dxt_chk.sv
module dxt_chk
  import dxt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       chunkReq,
  input logic       irq,
  input logic       dmaEnd,
  input logic       launchFail,
  input logic [2:0] status,
  input strobe_t    strb
);
  // R10
  req_end_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chunkReq && dmaEnd) |-> launchFail);

  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaEnd |=> !busy);

  // R4
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> busy);

  // R8
  adv_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv |=> (chunkReq || dmaEnd));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (status == ST_NONE));

  // R12
  stay_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dmaEnd) |=> busy);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    chunkReq |-> busy);
endmodule

bind disk_xfer_tracker dxt_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .chunkReq  (chunkReq),
  .irq       (irq),
  .dmaEnd    (dmaEnd),
  .launchFail(launchFail),
  .status    (status),
  .strb      (strb)
);

// File: tb/sim_disk_xfer_tracker.sv
module sim_disk_xfer_tracker;
  localparam int CLK_P = 10;
  localparam int ADDRW = 32;
  localparam int LENW  = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic             startOptical = 1'b0;
  logic [1:0]       startCmd = '0;
  logic [ADDRW-1:0] startAddr = '0;
  logic [LENW-1:0]  startLen = '0;
  logic [LENW-1:0]  dmaLen = '0;
  logic             launchFail = 1'b0;
  logic             chunkDone = 1'b0;
  logic             chunkErr = 1'b0;
  logic             busy;
  logic             chunkReq;
  logic [ADDRW+1:0] chunkAddr;
  logic [1:0]       chunkCmd;
  logic [2:0]       status;
  logic             irq;
  logic             dmaEnd;

  disk_xfer_tracker #(.ADDRW(ADDRW), .LENW(LENW)) u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  bit ended = 0;

  longint mSec, mRem, mOff, mChunk;
  int     mCmd, expStat;
  string  stTag;
  int     lenArr [0:15];

  task automatic chk(input longint act, input longint exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expAddr(input bit opt);
    return opt ? (mSec * 4 + (mOff >> 9)) : mSec;
  endfunction

  task automatic runCmd(input bit opt, input longint addr, input longint len,
                        input int cmd, input int nCh, input int errAt,
                        input int failAt, input bit pokeStart);
    bit fin = 0;
    bit cmpl;
    int k = 0;
    mSec = addr; mRem = len; mOff = 0; mChunk = 0;
    mCmd = opt ? 0 : cmd; expStat = 0; stTag = "R7";
    @(negedge clk);
    startReq = 1'b1; startOptical = opt; startCmd = 2'(cmd);
    startAddr = ADDRW'(addr); startLen = LENW'(len);
    @(posedge clk);
    while (!fin) begin
      @(negedge clk);
      startReq = 1'b0; chunkDone = 1'b0; chunkErr = 1'b0;
      dmaLen = (k < nCh) ? LENW'(lenArr[k]) : '0;
      launchFail = (k == failAt);
      #(CLK_P/4);
      cmpl = opt ? (mRem <= 0) : (mRem == 0);
      if (cmpl) begin
        expStat = opt ? 2 : 1;
        stTag = opt ? "R6" : "R4";
      end
      chk(irq, cmpl || (dmaLen != 0 && launchFail), opt ? "R6 irq" : "R4 irq");
      chk(dmaEnd, (dmaLen == 0) || launchFail, launchFail ? "R10 dmaEnd" : "R7 dmaEnd");
      chk(chunkReq, dmaLen != 0, "R8 chunkReq");
      if (dmaLen != 0) begin
        chk(chunkAddr, expAddr(opt), (k == 0) ? "R2 addr" : (opt ? "R5 addr" : "R3 addr"));
        chk(chunkCmd, mCmd, "R11 cmd");
      end
      if (dmaLen == 0) fin = 1;
      else begin
        mChunk = dmaLen;
        if (!opt) mOff = 0;
        if (launchFail) begin
          expStat = opt ? 4 : 3; stTag = "R10"; fin = 1;
        end
      end
      @(posedge clk);
      if (!fin) begin
        @(negedge clk);
        dmaLen = '0; launchFail = 1'b0;
        chunkDone = 1'b1; chunkErr = (k == errAt);
        if (pokeStart) begin
          startReq = 1'b1; startAddr = ADDRW'(addr + 777); startLen = '0;
        end
        #(CLK_P/4);
        if (chunkErr) begin
          chk(irq, 1, "R9 irq");
          chk(dmaEnd, 1, "R9 dmaEnd");
          expStat = opt ? 4 : 3; stTag = "R9"; fin = 1;
        end else if (opt) begin
          longint sum = mOff + mChunk;
          mRem -= mChunk;
          mSec += sum >> 11;
          mOff = sum & 2047;
        end else begin
          longint n = (mChunk + 511) >> 9;
          mSec += n;
          mRem -= n;
        end
        @(posedge clk);
        k++;
      end
    end
    @(negedge clk);
    startReq = 1'b0; chunkDone = 1'b0; chunkErr = 1'b0;
    dmaLen = '0; launchFail = 1'b0;
    #(CLK_P/4);
    chk(status, expStat, stTag);
    chk(busy, 0, "R7 busy");
    chk(dmaEnd, 0, "R7 idle dmaEnd");
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!ended) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(busy, 0, "R1 busy");
    chk(chunkReq, 0, "R1 chunkReq");
    chk(irq, 0, "R1 irq");
    chk(dmaEnd, 0, "R1 dmaEnd");
    chk(status, 0, "R1 status");
    rstN = 1'b1;
    @(posedge clk);

    // R3 rounding, R4 completion
    lenArr[0] = 512; lenArr[1] = 700;
    runCmd(0, 100, 3, 1, 2, -1, -1, 0);
    // R4 zero count completes on first pass
    runCmd(0, 55, 0, 0, 0, -1, -1, 0);
    // R5 offset carry across blocks, R6 completion
    lenArr[0] = 1000; lenArr[1] = 1500; lenArr[2] = 2500;
    runCmd(1, 10, 5000, 2, 3, -1, -1, 0);
    // R6 overshoot goes negative
    lenArr[0] = 3000; lenArr[1] = 100;
    runCmd(1, 3, 2000, 0, 2, -1, -1, 0);
    // R9 errors in both modes
    lenArr[0] = 512; lenArr[1] = 1024; lenArr[2] = 512;
    runCmd(0, 900, 4, 2, 3, 1, -1, 0);
    runCmd(1, 77, 6000, 0, 3, 0, -1, 0);
    // R10 launch failures
    runCmd(0, 400, 4, 1, 3, -1, 1, 0);
    runCmd(1, 8, 4000, 0, 3, -1, 0, 0);
    // R12 start during a command is ignored
    lenArr[0] = 600; lenArr[1] = 513; lenArr[2] = 2048;
    runCmd(0, 5000, 6, 2, 3, -1, -1, 1);
    runCmd(1, 12, 9000, 1, 3, -1, -1, 1);

    for (int i = 0; i < 40; i++) begin
      bit opt = $urandom_range(0, 1) == 1;
      int nCh = $urandom_range(0, 8);
      int errAt = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 8) : -1;
      int failAt = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 8) : -1;
      longint len = opt ? $urandom_range(0, 20000) : $urandom_range(0, 24);
      for (int j = 0; j < 16; j++) lenArr[j] = $urandom_range(1, 4096);
      runCmd(opt, $urandom_range(0, 1000000), len, $urandom_range(0, 2),
             nCh, errAt, failAt, $urandom_range(0, 3) == 0);
    end

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule